// File: doc/BRIEF.md
# Interleaved First-Order Recursive Filter

The block evaluates the recursion z(k) = x(k) + c·z(k−1) for several independent sample streams while owning only one adder and one multiplier. Samples from the streams are time-interleaved onto a single input port, one per clock, in a fixed round-robin order. Slot p of every frame of STREAMS cycles always carries stream p. The clock therefore runs at STREAMS times the per-stream symbol rate.

Both arithmetic units are pipelined: the adder has ADD_LAT register stages and the multiplier has MUL_LAT. A delay line of STREAMS − ADD_LAT − MUL_LAT balancing registers completes the feedback loop. Each stream's previous result reaches the adder in exactly the cycle when that stream's next sample arrives. Arithmetic is signed Q1.15 with a coefficient that can be changed at run time. The product is truncated toward minus infinity, and the sum wraps.

A valid flag and the stream index travel beside the data through a matching shift register. The output therefore names the stream whose updated state it carries, ADD_LAT cycles after the sample entered.

Top module: `ilv_recur_filter`

## Requirements
- R1: For a valid sample x on slot p, out_data equals x + T(c·z_prev), where z_prev is the state left by the previous visit of slot p. The result appears ADD_LAT cycles (1 by default) after the sample is taken.
- R2: T(c·z) is the full 32-bit signed product shifted right arithmetically by 15 and kept to 16 bits. This rounds toward minus infinity: 0.5·(−1 LSB) gives −1 LSB, and 0.5·(−3 LSB) gives −2 LSB.
- R3: The 16-bit sum wraps modulo 2^16 on overflow, with no saturation.
- R4: Slot p (cycle count since reset modulo STREAMS) holds the state of stream p alone. Values on other slots never alter it, and each result returns to the adder exactly STREAMS cycles after it was produced.
- R5: A slot with in_valid low is treated as a zero sample. That stream's state advances to T(c·z_prev), and out_valid is low for that slot.
- R6: out_valid and out_idx equal in_valid and in_idx delayed by ADD_LAT cycles.
- R7: A synchronous active-high reset clears every register in the loop and the side-band. While reset is held, out_valid = 0, out_idx = 0 and out_data = 0. After reset, every stream restarts from a zero history, so the first frame's outputs equal their inputs.
- R8: The coefficient that scales a stream's old state for the sample entering in cycle S is the value of coef_i in cycle S − MUL_LAT (3 by default).

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock, STREAMS times the per-stream rate |
| rst | input | 1 | Synchronous active-high reset |
| coef_i | input | 16 | Signed Q1.15 feedback coefficient c |
| in_valid | input | 1 | Current slot carries a sample |
| in_idx | input | IDX_W (3) | Stream index of the current slot |
| in_data | input | 16 | Signed Q1.15 input sample x |
| out_valid | output | 1 | Output slot carries a result |
| out_idx | output | IDX_W (3) | Stream index of the result |
| out_data | output | 16 | Signed Q1.15 updated state z |

## Verification
An impulse on one slot with a coefficient of one half, next to distinct constants on the other slots, shows that each stream decays on its own and that the loop length is right: a loop that is one register too long or too short mixes neighbouring streams. Negative inputs with coefficients of plus and minus one half separate floor truncation from rounding toward zero. Near-full-scale inputs with a coefficient just under one expose wrap against saturation. Frames with idle slots, a coefficient switch in the middle of a frame, a reset in the middle of a run, and pseudo-random data with changing coefficients cover the zero-sample rule, the coefficient timing and the restart from zero history.

// File: rtl/ilv_pkg.sv
package ilv_pkg;
  // Sample format: signed fixed point, one sign/integer bit
  parameter int DATA_W = 16;
  parameter int FRAC_W = 15;

  typedef logic signed [DATA_W-1:0] sample_t;

  // Full-precision product scaled back to the sample format by an
  // arithmetic right shift (floor), upper bits discarded.
  function automatic sample_t mul_floor(input sample_t a, input sample_t b);
    logic signed [2*DATA_W-1:0] wide;
    wide = {{DATA_W{a[DATA_W-1]}}, a} * {{DATA_W{b[DATA_W-1]}}, b};
    return sample_t'(wide >>> FRAC_W);
  endfunction
endpackage

// File: rtl/ilv_delay_line.sv
module ilv_delay_line #(
  parameter int W     = 16,
  parameter int DEPTH = 1
) (
  input  logic         clk,
  input  logic         rst,
  input  logic [W-1:0] d_i,
  output logic [W-1:0] d_o
);
  generate
    if (DEPTH == 0) begin : g_wire
      assign d_o = d_i;
    end else begin : g_regs
      logic [W-1:0] stg [DEPTH];
      always_ff @(posedge clk) begin
        if (rst) begin
          for (int i = 0; i < DEPTH; i++) stg[i] <= '0;
        end else begin
          stg[0] <= d_i;
          for (int i = 1; i < DEPTH; i++) stg[i] <= stg[i-1];
        end
      end
      assign d_o = stg[DEPTH-1];
    end
  endgenerate
endmodule

// File: rtl/ilv_mul_pipe.sv
module ilv_mul_pipe
  import ilv_pkg::*;
#(
  parameter int LAT = 3
) (
  input  logic    clk,
  input  logic    rst,
  input  sample_t z_i,
  input  sample_t c_i,
  output sample_t p_o
);
  sample_t p_first;

  // First stage registers the truncated product
  always_ff @(posedge clk) begin
    if (rst) p_first <= '0;
    else     p_first <= mul_floor(z_i, c_i);
  end

  // Remaining stages model the deeper multiplier pipeline
  ilv_delay_line #(.W(DATA_W), .DEPTH(LAT-1)) u_tail (
    .clk (clk),
    .rst (rst),
    .d_i (p_first),
    .d_o (p_o)
  );
endmodule

// File: rtl/ilv_add_pipe.sv
module ilv_add_pipe
  import ilv_pkg::*;
#(
  parameter int LAT = 1
) (
  input  logic    clk,
  input  logic    rst,
  input  sample_t x_i,
  input  sample_t fb_i,
  output sample_t sum_o
);
  sample_t s_first;

  // Modular sum: overflow wraps
  always_ff @(posedge clk) begin
    if (rst) s_first <= '0;
    else     s_first <= x_i + fb_i;
  end

  ilv_delay_line #(.W(DATA_W), .DEPTH(LAT-1)) u_tail (
    .clk (clk),
    .rst (rst),
    .d_i (s_first),
    .d_o (sum_o)
  );
endmodule

// File: rtl/ilv_recur_filter.sv
module ilv_recur_filter
  import ilv_pkg::*;
#(
  parameter int STREAMS = 8,
  parameter int ADD_LAT = 1,
  parameter int MUL_LAT = 3,
  parameter int IDX_W   = (STREAMS > 1) ? $clog2(STREAMS) : 1
) (
  input  logic                      clk,
  input  logic                      rst,
  input  logic signed [DATA_W-1:0]  coef_i,
  input  logic                      in_valid,
  input  logic        [IDX_W-1:0]   in_idx,
  input  logic signed [DATA_W-1:0]  in_data,
  output logic                      out_valid,
  output logic        [IDX_W-1:0]   out_idx,
  output logic signed [DATA_W-1:0]  out_data
);
  localparam int BAL_LAT = STREAMS - ADD_LAT - MUL_LAT;
  localparam int TAG_W   = IDX_W + 1;

  // Elaboration-time guards on the loop budget
  if (BAL_LAT < 0) begin : g_loop_too_short
    $error("loop of %0d streams cannot hold %0d adder and %0d multiplier stages",
           STREAMS, ADD_LAT, MUL_LAT);
  end
  if (ADD_LAT < 1 || MUL_LAT < 1) begin : g_stage_min
    $error("adder and multiplier need at least one register each");
  end

  sample_t x_eff;
  sample_t fb_prod;
  sample_t z_new;
  sample_t z_bal;

  // Empty slot behaves as a zero sample
  assign x_eff = in_valid ? sample_t'(in_data) : '0;

  ilv_add_pipe #(.LAT(ADD_LAT)) u_add (
    .clk   (clk),
    .rst   (rst),
    .x_i   (x_eff),
    .fb_i  (fb_prod),
    .sum_o (z_new)
  );

  // Padding so that adder + balance + multiplier spans one full frame
  ilv_delay_line #(.W(DATA_W), .DEPTH(BAL_LAT)) u_bal (
    .clk (clk),
    .rst (rst),
    .d_i (z_new),
    .d_o (z_bal)
  );

  ilv_mul_pipe #(.LAT(MUL_LAT)) u_mul (
    .clk (clk),
    .rst (rst),
    .z_i (z_bal),
    .c_i (sample_t'(coef_i)),
    .p_o (fb_prod)
  );

  // Side-band follows the adder latency
  logic [TAG_W-1:0] tag_in;
  logic [TAG_W-1:0] tag_out;
  assign tag_in = {in_valid, in_idx};

  ilv_delay_line #(.W(TAG_W), .DEPTH(ADD_LAT)) u_tag (
    .clk (clk),
    .rst (rst),
    .d_i (tag_in),
    .d_o (tag_out)
  );

  assign out_valid = tag_out[TAG_W-1];
  assign out_idx   = tag_out[IDX_W-1:0];
  assign out_data  = z_new;
endmodule

// File: rtl/ilv_recur_chk.sv
module ilv_recur_chk #(
  parameter int STREAMS = 8,
  parameter int ADD_LAT = 1,
  parameter int IDX_W   = 3,
  parameter int W       = 16
) (
  input logic                 clk,
  input logic                 rst,
  input logic                 in_valid,
  input logic        [IDX_W-1:0] in_idx,
  input logic signed [W-1:0]  in_data,
  input logic                 out_valid,
  input logic        [IDX_W-1:0] out_idx,
  input logic signed [W-1:0]  out_data
);
  localparam int CW = $clog2(STREAMS + 1) + 1;

  logic             v_sr  [ADD_LAT];
  logic [IDX_W-1:0] i_sr  [ADD_LAT];
  logic [W-1:0]     x_sr  [ADD_LAT];
  logic             fp_sr [ADD_LAT];
  logic [CW-1:0]    since_rst;

  always_ff @(posedge clk) begin
    if (rst) begin
      for (int i = 0; i < ADD_LAT; i++) begin
        v_sr[i]  <= 1'b0;
        i_sr[i]  <= '0;
        x_sr[i]  <= '0;
        fp_sr[i] <= 1'b1;
      end
      since_rst <= '0;
    end else begin
      v_sr[0]  <= in_valid;
      i_sr[0]  <= in_idx;
      x_sr[0]  <= in_valid ? in_data : '0;
      fp_sr[0] <= (since_rst < CW'(STREAMS));
      for (int i = 1; i < ADD_LAT; i++) begin
        v_sr[i]  <= v_sr[i-1];
        i_sr[i]  <= i_sr[i-1];
        x_sr[i]  <= x_sr[i-1];
        fp_sr[i] <= fp_sr[i-1];
      end
      if (since_rst < CW'(STREAMS)) since_rst <= since_rst + 1'b1;
    end
  end

  // R6: valid flag delayed by the adder latency
  p_valid_track_r6: assert property (@(posedge clk) disable iff (rst)
    out_valid == v_sr[ADD_LAT-1]);

  // R6: stream index delayed with the data
  p_idx_track_r6: assert property (@(posedge clk) disable iff (rst)
    out_idx == i_sr[ADD_LAT-1]);

  // R7: outputs are cleared by reset
  p_reset_clear_r7: assert property (@(posedge clk) disable iff (rst)
    $past(rst) |-> (!out_valid && out_data == '0 && out_idx == '0));

  // R7: during the first frame after reset every history is zero
  p_first_pass_r7: assert property (@(posedge clk) disable iff (rst)
    fp_sr[ADD_LAT-1] |-> (out_data == $signed(x_sr[ADD_LAT-1])));
endmodule

bind ilv_recur_filter ilv_recur_chk #(
  .STREAMS (STREAMS),
  .ADD_LAT (ADD_LAT),
  .IDX_W   (IDX_W),
  .W       (ilv_pkg::DATA_W)
) u_chk (
  .clk       (clk),
  .rst       (rst),
  .in_valid  (in_valid),
  .in_idx    (in_idx),
  .in_data   (in_data),
  .out_valid (out_valid),
  .out_idx   (out_idx),
  .out_data  (out_data)
);

// File: tb/ilv_recur_filter_tb_top.sv
module ilv_recur_filter_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int NS   = 8;
  localparam int MLAT = 3;

  logic clk = 1'b0;
  always #(CLK_PERIOD/2) clk = ~clk;

  logic               rst = 1'b1;
  logic signed [15:0] coef_i = '0;
  logic               in_valid = 1'b0;
  logic [2:0]         in_idx = '0;
  logic signed [15:0] in_data = '0;
  logic               out_valid;
  logic [2:0]         out_idx;
  logic signed [15:0] out_data;

  ilv_recur_filter dut_i (
    .clk (clk), .rst (rst), .coef_i (coef_i),
    .in_valid (in_valid), .in_idx (in_idx), .in_data (in_data),
    .out_valid (out_valid), .out_idx (out_idx), .out_data (out_data)
  );

  int n_cmp = 0;
  int n_bad = 0;
  logic signed [15:0] zst   [NS];
  logic signed [15:0] chist [MLAT+1];
  logic signed [15:0] coef_r = '0;
  int    slot = 0;
  bit    pend = 0;
  bit    ev;
  logic [2:0] ei;
  logic signed [15:0] ed;
  string etag;
  logic [15:0] lfsr = 16'hACE1;

  function automatic logic signed [15:0] mt(input logic signed [15:0] c,
                                            input logic signed [15:0] z);
    longint p;
    p = longint'(c) * longint'(z);
    return 16'(p >>> 15);
  endfunction

  function automatic logic [15:0] nxt(input logic [15:0] s);
    return {s[14:0], s[15] ^ s[13] ^ s[12] ^ s[10]};
  endfunction

  task automatic chk(input bit ok, input string tag, input string what,
                     input int act, input int expv);
    n_cmp++;
    if (!ok) begin
      n_bad++;
      $display("FAIL %s %s: actual %0h expected %0h", tag, what, act, expv);
    end
  endtask

  task automatic cmp_pending();
    if (pend) begin
      chk(out_valid === ev, "R6", "out_valid", int'(out_valid), int'(ev));
      chk(out_idx === ei, "R6", "out_idx", int'(out_idx), int'(ei));
      if (ev) chk(out_data === ed, etag, "out_data",
                  int'(16'(out_data)), int'(16'(ed)));
      pend = 0;
    end
  endtask

  // One slot: check the previous result, model and drive the new sample
  task automatic cyc(input bit v, input logic signed [15:0] x, input string tag);
    cmp_pending();
    for (int i = MLAT; i > 0; i--) chist[i] = chist[i-1];
    chist[0] = coef_r;
    ed = (v ? x : 16'sd0) + mt(chist[MLAT], zst[slot]);   // R8 coefficient tap
    zst[slot] = ed;
    ev = v; ei = 3'(slot); etag = tag; pend = 1;
    in_valid = v; in_idx = 3'(slot); in_data = x; coef_i = coef_r;
    slot = (slot + 1) % NS;
    @(negedge clk);
  endtask

  task automatic frame(input logic [7:0] mask, input logic signed [15:0] base,
                       input logic signed [15:0] step, input string tag);
    for (int i = 0; i < NS; i++) cyc(mask[i], 16'(base + i * step), tag);
  endtask

  task automatic do_reset();
    cmp_pending();
    rst = 1'b1; in_valid = 1'b0; in_data = '0; in_idx = '0;
    repeat (3) @(negedge clk);
    chk(out_valid === 1'b0, "R7", "reset out_valid", int'(out_valid), 0);
    chk(out_data === 16'sd0, "R7", "reset out_data", int'(16'(out_data)), 0);
    chk(out_idx === 3'd0, "R7", "reset out_idx", int'(out_idx), 0);
    rst = 1'b0;
    for (int i = 0; i < NS; i++) zst[i] = '0;
    for (int i = 0; i <= MLAT; i++) chist[i] = '0;
    slot = 0;
  endtask

  task automatic t_impulse();   // R1, R4
    do_reset();
    coef_r = 16'sh4000;
    for (int i = 0; i < NS; i++) cyc(1'b1, (i == 0) ? 16'sh2000 : 16'(i * 256), "R1");
    repeat (4) frame(8'hFF, 16'sd0, 16'sd0, "R4");
  endtask

  task automatic t_trunc();     // R2
    do_reset();
    coef_r = 16'sh4000;
    frame(8'hFF, -16'sd1, -16'sd2, "R2");
    frame(8'hFF, 16'sd0, 16'sd0, "R2");      // -1*0.5 -> -1, -3*0.5 -> -2
    coef_r = 16'shC000;
    frame(8'hFF, 16'sd3, 16'sd0, "R2");
    frame(8'hFF, 16'sd0, 16'sd0, "R2");
    frame(8'hFF, 16'sd0, 16'sd0, "R2");
  endtask

  task automatic t_wrap();      // R3
    do_reset();
    coef_r = 16'sh7FFF;
    frame(8'hFF, 16'sh7000, 16'sd0, "R3");
    frame(8'hFF, 16'sh7000, 16'sd0, "R3");   // 0x7000 + 0x6FFF wraps negative
    frame(8'hFF, -16'sh7000, 16'sd0, "R3");
    frame(8'hFF, -16'sh7000, 16'sd0, "R3");
  endtask

  task automatic t_idle();      // R5
    do_reset();
    coef_r = 16'sh6000;
    frame(8'hFF, 16'sh1000, 16'sh0800, "R5");
    frame(8'h55, 16'sh0400, 16'sd0, "R5");
    frame(8'h00, 16'sh0400, 16'sd0, "R5");
    frame(8'hFF, 16'sd0, 16'sd0, "R5");
  endtask

  task automatic t_coef();      // R8
    coef_r = 16'sh2000;
    frame(8'hFF, 16'sh0300, 16'sh0111, "R8");
    for (int i = 0; i < NS; i++) begin
      if (i == 3) coef_r = 16'shA000;
      cyc(1'b1, 16'(16'sh0500 - i * 16'sh0123), "R8");
    end
    frame(8'hFF, 16'sd0, 16'sd0, "R8");
    frame(8'hFF, 16'sd0, 16'sd0, "R8");
  endtask

  task automatic t_mixed();     // R1, R4
    for (int f = 0; f < 12; f++) begin
      lfsr = nxt(lfsr);
      coef_r = $signed(lfsr);
      for (int i = 0; i < NS; i++) begin
        lfsr = nxt(lfsr);
        cyc(lfsr[0] | lfsr[5], $signed(lfsr), "R4");
      end
    end
  endtask

  task automatic t_mid_reset(); // R7
    coef_r = 16'sh5555;
    frame(8'hFF, 16'sh1234, 16'sh0101, "R1");
    do_reset();
    frame(8'hFF, -16'sh0200, 16'sh0077, "R7");   // first frame: output = input
    frame(8'hFF, 16'sd0, 16'sd0, "R1");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    n_cmp++; n_bad++;
    $display("FAIL watchdog: actual timeout expected completion");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end

  initial begin : main
    for (int i = 0; i < NS; i++) zst[i] = '0;
    for (int i = 0; i <= MLAT; i++) chist[i] = '0;
    @(negedge clk);
    t_impulse();
    t_trunc();
    t_wrap();
    t_idle();
    t_coef();
    t_mixed();
    t_mid_reset();
    cmp_pending();
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_cmp, n_bad);
    $finish;
  end
endmodule